// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block sits behind the input filter of a bank of general-purpose pins and turns each filtered pin level into two sticky status flags: an interrupt flag and a wake flag. Each pin picks its own trigger type. It can sense a level (high or low) or an edge (rising, falling, or both). Interrupt status is gated by a per-pin enable. A separate per-pin permission bit decides whether latched status may raise the pin's request line. Software clears either flag with a write-one strobe.

The block also holds a shared settle window. While the global window switch is on, a write to any pin's debounce settings starts a countdown of programmable length. Until the countdown ends, no pin can set new interrupt or wake status, and every pin's enable reads back as 0. All inputs and outputs are plain control and status pins. There is no streaming data path, so no valid/ready handshake is needed.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset every status flag, request, enable readback and the busy flag are 0.
- R2: In edge mode (`trig_lvl`=0), trigger select 2'b00 sets interrupt status on a rising edge and 2'b01 on a falling edge. The status shows one clock after the edge is sampled and stays set after the pin returns.
- R3: In edge mode, trigger select 2'b10 sets interrupt status on both rising and falling edges.
- R4: In level mode (`trig_lvl`=1), select 2'b00 sets status while the pin is high and 2'b01 while it is low. A clear strobe leaves status set if the level is still asserted. A clear strobe drops it to 0 once the level is gone.
- R5: In level mode, select 2'b10 never sets status. Select 2'b11 never sets status in either mode.
- R6: An interrupt status bit is cleared by a one on its `irq_clr` bit. A trigger in the same cycle wins over the clear.
- R7: With `irq_en`=0, no new interrupt status is set. Status that is already latched is kept.
- R8: `irq_req` is 1 only when the pin is pending and its `irq_perm` bit is 1.
- R9: A trigger event sets wake status when any of the pin's three wake-enable bits (bit 0, 1 or 2 of its field) is set, whatever `irq_en` is. `wake_clr` clears it. With all three bits at 0, no wake status is set.
- R10: `pend` is 1 when either the interrupt or the wake status of the pin is set.
- R11: With `blk_on`=1, a `dbnc_wr` pulse on any pin keeps `blk_busy` high for exactly `blk_len` cycles, starting the cycle after the pulse. During that time no pin sets new interrupt or wake status.
- R12: `en_rd` shows `irq_en`, but reads 0 on every pin while `blk_busy` is 1. With `blk_on`=0, debounce writes start no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NPINS | Filtered pin levels |
| trig_lvl | input | NPINS | 1 = level sensing, 0 = edge sensing |
| trig_sel | input | 2*NPINS | Per-pin trigger select: 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| irq_en | input | NPINS | Interrupt status enable |
| irq_perm | input | NPINS | Permission for status to raise the request |
| wake_en | input | 3*NPINS | Three wake-enable bits per pin, one per sleep state |
| irq_clr | input | NPINS | Write-one strobe clearing interrupt status |
| wake_clr | input | NPINS | Write-one strobe clearing wake status |
| dbnc_wr | input | NPINS | Strobe marking a write to a pin's debounce settings |
| blk_on | input | 1 | Global switch for the settle window |
| blk_len | input | LEN_W | Settle window length in cycles |
| irq_sts | output | NPINS | Interrupt status |
| wake_sts | output | NPINS | Wake status |
| pend | output | NPINS | Interrupt or wake status set |
| irq_req | output | NPINS | Permitted pending request |
| en_rd | output | NPINS | Enable readback, forced to 0 during the window |
| blk_busy | output | 1 | Settle window active |

## Verification
The bench checks that trigger select 2'b10 in edge mode fires on both edges. A design that decoded it as rising only would miss the falling edge. It checks that the same select in level mode stays silent; a design that treated it as "any level" would latch at once. It clears a level-triggered status while the level is still asserted, to catch a design that loses a live level. It also counts the settle window cycle by cycle and sends an edge through it: an off-by-one counter would shift `blk_busy` by a cycle, and a missing gate would let that edge set status.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    TRIG_HI   = 2'b00,
    TRIG_LO   = 2'b01,
    TRIG_BOTH = 2'b10,
    TRIG_NONE = 2'b11
  } trig_sel_e;

  localparam int unsigned WAKE_STATES = 3;
endpackage

// File: rtl/gpio_evt_trig.sv
module gpio_evt_trig
  import gpio_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       lvl_mode,
  input  logic [1:0] sel,
  output logic       hit
);
  logic prev_q;
  logic rise, fall;
  trig_sel_e sel_e;

  assign sel_e = trig_sel_e'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    hit = 1'b0;
    if (lvl_mode) begin
      unique case (sel_e)
        TRIG_HI: hit = lvl;
        TRIG_LO: hit = ~lvl;
        default: hit = 1'b0;
      endcase
    end else begin
      unique case (sel_e)
        TRIG_HI:   hit = rise;
        TRIG_LO:   hit = fall;
        TRIG_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_stat.sv
module gpio_evt_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic irq_en,
  input  logic wake_any,
  input  logic blocked,
  input  logic irq_clr,
  input  logic wake_clr,
  output logic irq_sts,
  output logic wake_sts
);
  logic set_irq, set_wake;

  assign set_irq  = hit & irq_en & ~blocked;
  assign set_wake = hit & wake_any & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sts  <= 1'b0;
      wake_sts <= 1'b0;
    end else begin
      if (set_irq)      irq_sts <= 1'b1;
      else if (irq_clr) irq_sts <= 1'b0;
      if (set_wake)      wake_sts <= 1'b1;
      else if (wake_clr) wake_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_evt_blk.sv
module gpio_evt_blk #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_on,
  input  logic             any_wr,
  input  logic [LEN_W-1:0] blk_len,
  output logic             busy
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (blk_on && any_wr) cnt_q <= blk_len;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned LEN_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPINS-1:0]             pin_lvl,
  input  logic [NPINS-1:0]             trig_lvl,
  input  logic [2*NPINS-1:0]           trig_sel,
  input  logic [NPINS-1:0]             irq_en,
  input  logic [NPINS-1:0]             irq_perm,
  input  logic [WAKE_STATES*NPINS-1:0] wake_en,
  input  logic [NPINS-1:0]             irq_clr,
  input  logic [NPINS-1:0]             wake_clr,
  input  logic [NPINS-1:0]             dbnc_wr,
  input  logic                         blk_on,
  input  logic [LEN_W-1:0]             blk_len,
  output logic [NPINS-1:0]             irq_sts,
  output logic [NPINS-1:0]             wake_sts,
  output logic [NPINS-1:0]             pend,
  output logic [NPINS-1:0]             irq_req,
  output logic [NPINS-1:0]             en_rd,
  output logic                         blk_busy
);
  logic busy;

  gpio_evt_blk #(.LEN_W(LEN_W)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_on  (blk_on),
    .any_wr  (|dbnc_wr),
    .blk_len (blk_len),
    .busy    (busy)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic hit;

    gpio_evt_trig u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_lvl[i]),
      .lvl_mode (trig_lvl[i]),
      .sel      (trig_sel[2*i +: 2]),
      .hit      (hit)
    );

    gpio_evt_stat u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .irq_en   (irq_en[i]),
      .wake_any (|wake_en[WAKE_STATES*i +: WAKE_STATES]),
      .blocked  (busy),
      .irq_clr  (irq_clr[i]),
      .wake_clr (wake_clr[i]),
      .irq_sts  (irq_sts[i]),
      .wake_sts (wake_sts[i])
    );
  end

  assign pend     = irq_sts | wake_sts;
  assign irq_req  = pend & irq_perm;
  assign en_rd    = busy ? '0 : irq_en;
  assign blk_busy = busy;
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] irq_perm,
  input logic [NPINS-1:0] irq_sts,
  input logic [NPINS-1:0] wake_sts,
  input logic [NPINS-1:0] irq_req,
  input logic [NPINS-1:0] en_rd,
  input logic             blk_busy
);
  // R11: nothing new latches while the window is open
  a_r11_no_set_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy |=> (((irq_sts & ~$past(irq_sts)) == '0) &&
                  ((wake_sts & ~$past(wake_sts)) == '0)));

  // R12: enables read back as zero during the window
  a_r12_en_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy |-> (en_rd == '0));

  // R7: a disabled pin gains no interrupt status
  a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_sts & ~$past(irq_sts) & ~$past(irq_en)) == '0));

  // R8: requests only with permission and pending status
  a_r8_req_permitted: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~(irq_perm & (irq_sts | wake_sts))) == '0);
endmodule

bind gpio_evt_top gpio_evt_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_en   (irq_en),
  .irq_perm (irq_perm),
  .irq_sts  (irq_sts),
  .wake_sts (wake_sts),
  .irq_req  (irq_req),
  .en_rd    (en_rd),
  .blk_busy (blk_busy)
);

// File: tb/gpio_evt_top_tb.sv
module gpio_evt_top_tb;
  localparam int NP = 8;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]   pin_lvl = '0, trig_lvl = '0, irq_en = '0, irq_perm = '0;
  logic [2*NP-1:0] trig_sel = '0;
  logic [3*NP-1:0] wake_en = '0;
  logic [NP-1:0]   irq_clr = '0, wake_clr = '0, dbnc_wr = '0;
  logic            blk_on = 1'b0;
  logic [LW-1:0]   blk_len = '0;
  logic [NP-1:0]   irq_sts, wake_sts, pend, irq_req, en_rd;
  logic            blk_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_evt_top #(.NPINS(NP), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_lvl(trig_lvl),
    .trig_sel(trig_sel), .irq_en(irq_en), .irq_perm(irq_perm),
    .wake_en(wake_en), .irq_clr(irq_clr), .wake_clr(wake_clr),
    .dbnc_wr(dbnc_wr), .blk_on(blk_on), .blk_len(blk_len),
    .irq_sts(irq_sts), .wake_sts(wake_sts), .pend(pend),
    .irq_req(irq_req), .en_rd(en_rd), .blk_busy(blk_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change at negedge, outputs read at the following negedge
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_clr(input int p);
    irq_clr[p] = 1'b1; step(); irq_clr[p] = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq_sts", irq_sts, 0);
    check("R1 wake_sts", wake_sts, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 en_rd", en_rd, 0);
    check("R1 blk_busy", blk_busy, 0);
  endtask

  task automatic t_rise_fall;
    irq_en[0] = 1; trig_sel[1:0] = 2'b00;
    irq_en[1] = 1; trig_sel[3:2] = 2'b01;
    pin_lvl[0] = 1; pin_lvl[1] = 1; step();
    check("R2 rising sets", irq_sts[0], 1);
    check("R2 falling ignores rise", irq_sts[1], 0);
    check("R8 no req without perm", irq_req[0], 0);
    check("R10 pend from irq", pend[0], 1);
    pin_lvl[0] = 0; pin_lvl[1] = 0; step();
    check("R2 edge status latched", irq_sts[0], 1);
    check("R2 falling sets", irq_sts[1], 1);
    irq_perm[0] = 1; step();
    check("R8 req with perm", irq_req[0], 1);
    pulse_clr(0);
    check("R6 clear", irq_sts[0], 0);
    check("R8 req drops", irq_req[0], 0);
    pulse_clr(1);
  endtask

  task automatic t_both;
    irq_en[2] = 1; trig_sel[5:4] = 2'b10;
    pin_lvl[2] = 1; step();
    check("R3 both rise", irq_sts[2], 1);
    pulse_clr(2);
    check("R3 cleared", irq_sts[2], 0);
    pin_lvl[2] = 0; step();
    check("R3 both fall", irq_sts[2], 1);
    // clear and new edge in the same cycle: set wins
    pin_lvl[2] = 1; irq_clr[2] = 1; step(); irq_clr[2] = 0;
    check("R6 set beats clear", irq_sts[2], 1);
    pulse_clr(2);
    pin_lvl[2] = 0; step(); pulse_clr(2);
  endtask

  task automatic t_level;
    irq_en[3] = 1; trig_lvl[3] = 1; trig_sel[7:6] = 2'b00;
    step(2);
    check("R4 low level idle", irq_sts[3], 0);
    pin_lvl[3] = 1; step();
    check("R4 high level sets", irq_sts[3], 1);
    pulse_clr(3);
    check("R4 live level survives clear", irq_sts[3], 1);
    pin_lvl[3] = 0; step();
    pulse_clr(3);
    check("R4 clear after level gone", irq_sts[3], 0);
    trig_sel[7:6] = 2'b01; step();
    check("R4 low-active level sets", irq_sts[3], 1);
    trig_sel[7:6] = 2'b11; step(); pulse_clr(3);
    check("R5 select 11 level silent", irq_sts[3], 0);
    irq_en[4] = 1; trig_lvl[4] = 1; trig_sel[9:8] = 2'b10;
    pin_lvl[4] = 1; step(3);
    check("R5 level both silent", irq_sts[4], 0);
    pin_lvl[4] = 0; step(3);
    check("R5 level both silent low", irq_sts[4], 0);
  endtask

  task automatic t_enable;
    irq_en[5] = 0; trig_sel[11:10] = 2'b00;
    pin_lvl[5] = 1; step();
    check("R7 disabled no set", irq_sts[5], 0);
    pin_lvl[5] = 0; irq_en[5] = 1; step();
    check("R12 en_rd follows", en_rd[5], 1);
    pin_lvl[5] = 1; step();
    check("R7 enabled sets", irq_sts[5], 1);
    irq_en[5] = 0; pin_lvl[5] = 0; step(2);
    check("R7 latched kept", irq_sts[5], 1);
    pulse_clr(5);
  endtask

  task automatic t_wake;
    trig_sel[13:12] = 2'b00; irq_en[6] = 0; wake_en[20:18] = 3'b010;
    pin_lvl[6] = 1; step();
    check("R9 wake sets", wake_sts[6], 1);
    check("R9 irq untouched", irq_sts[6], 0);
    check("R10 pend from wake", pend[6], 1);
    wake_clr[6] = 1; step(); wake_clr[6] = 0;
    check("R9 wake clear", wake_sts[6], 0);
    wake_en[20:18] = 3'b000; pin_lvl[6] = 0; step(); pin_lvl[6] = 1; step();
    check("R9 no wake when disabled", wake_sts[6], 0);
    pin_lvl[6] = 0; step();
  endtask

  task automatic t_window;
    irq_en = '1; trig_lvl = '0; trig_sel[1:0] = 2'b00; pin_lvl[0] = 0;
    blk_on = 0; blk_len = 12'd5;
    dbnc_wr[7] = 1; step(); dbnc_wr[7] = 0;
    check("R12 off no window", blk_busy, 0);
    blk_on = 1;
    dbnc_wr[7] = 1; step(); dbnc_wr[7] = 0;
    check("R11 busy starts", blk_busy, 1);
    check("R12 en hidden", en_rd, 0);
    pin_lvl[0] = 1; step();
    check("R11 edge blocked", irq_sts[0], 0);
    step(3);
    check("R11 busy at last cycle", blk_busy, 1);
    step();
    check("R11 busy ends", blk_busy, 0);
    check("R12 en restored", en_rd, {NP{1'b1}});
    pin_lvl[0] = 0; step(); pin_lvl[0] = 1; step();
    check("R11 edge after window", irq_sts[0], 1);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_rise_fall();
    t_both();
    t_level();
    t_enable();
    t_wake();
    t_window();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule